// File: doc/BRIEF.md
# Binary Hopfield Network Update Engine

This block evaluates a small binary Hopfield network. It holds a fixed number of neurons, each carrying a 0/1 activation, together with a symmetric matrix of signed 8-bit edge weights and one signed threshold per neuron. All of these are loaded through a write port. That port can either overwrite an entry or add to it, so several small gate networks can be merged into one: a shared neuron sums its thresholds and a shared edge sums its weights.

A start pulse loads the forced values of the clamped neurons. The engine then visits the neurons in ascending index order. For each neuron it spends one cycle per network neuron adding up the energy gradient, and from that sum it decides the neuron's new value. A positive gradient drives the neuron to 1, a negative one drives it to 0, and a zero gradient leaves it as it is. Clamped neurons are never rewritten, but they still feed every other neuron's gradient. Because of this, forcing a gate's inputs settles its output, and forcing its output justifies its inputs. Once a whole sweep goes by without any activation changing, the engine raises its stable output and keeps the activation vector frozen until the next start.

Top module: `hop_engine`

## Requirements
- R1: After reset all activations are 0, stable is 0, and every weight and threshold is 0. A run on this reset network finishes with all activations at 0.
- R2: When wr_thr is 0, a write sets the edge weight between wr_row and wr_col in both directions. When wr_thr is 1, it sets the threshold of neuron wr_row. With wr_accum at 1 the data is added to the stored value instead of replacing it. Sums are saturated to the range -2^(W-1) to 2^(W-1)-1.
- R3: A weight write with wr_row equal to wr_col has no effect, and a neuron's own activation never enters its own gradient.
- R4: The gradient of neuron k is its threshold plus the sum of weight(j,k) over every other neuron j whose activation is 1. The neuron becomes 1 if the gradient is above 0 and becomes 0 if it is below 0. It keeps its value if the gradient equals 0.
- R5: Neurons are updated one at a time in ascending index order, N cycles per neuron. At most one activation bit changes in any clock cycle.
- R6: On an accepted start, each neuron whose clamp_en bit is 1 takes its clamp_val bit. During the run that neuron is never updated, but it still contributes to the other neurons' gradients.
- R7: stable is 0 in the cycle after an accepted start. It rises at the end of the first complete sweep that changes no activation, so the time from the start edge to stable equals the number of sweeps times N*N cycles.
- R8: Networks built by accumulating the writes of several gates settle to a state that agrees with all of those gates. This holds for forward propagation from forced inputs and for backward justification from a forced output.
- R9: While stable is 1 and no start arrives, the activation vector does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for weights or thresholds |
| wr_thr | input | 1 | 1 writes a threshold, 0 writes an edge weight |
| wr_accum | input | 1 | 1 adds the data to the stored value, 0 replaces it |
| wr_row | input | $clog2(N) | Neuron index (threshold target, or first end of the edge) |
| wr_col | input | $clog2(N) | Second end of the edge |
| wr_data | input | W | Signed two's complement write data |
| clamp_en | input | N | Per-neuron clamp enable, held for the whole run |
| clamp_val | input | N | Per-neuron forced value |
| start | input | 1 | Begin a settling run (accepted only when idle) |
| stable | output | 1 | High once a full sweep has made no change |
| act | output | N | Activation vector |

## Verification
The bench builds the engine with N = 6 and W = 8. Six neurons are enough to chain two two-input AND sub-networks, which exercises merged thresholds, forward settling, multi-sweep backward justification and the zero-gradient case. They also leave one isolated neuron whose threshold alone decides its value. With 8-bit data, two writes are enough to reach both saturation limits. On that isolated neuron, the stored value and a self-edge write each show up directly in the neuron's final activation.

// File: rtl/hop_pkg.sv
package hop_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } seq_state_e;

  // Saturating signed add into a w-bit two's complement range.
  function automatic int hop_sat_add(input int a, input int b, input int w);
    int hi;
    int lo;
    int s;
    hi = (1 <<< (w - 1)) - 1;
    lo = -(1 <<< (w - 1));
    s  = a + b;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s;
  endfunction

  // Sign rule: positive -> 1, negative -> 0, zero -> hold.
  function automatic logic hop_next_bit(input logic cur, input int grad);
    if (grad > 0) return 1'b1;
    if (grad < 0) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/hop_param_store.sv
module hop_param_store #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_thr,
  input  logic                wr_accum,
  input  logic [IW-1:0]       wr_row,
  input  logic [IW-1:0]       wr_col,
  input  logic signed [W-1:0] wr_data,
  input  logic [IW-1:0]       rd_src,
  input  logic [IW-1:0]       rd_dst,
  output logic signed [W-1:0] rd_weight,
  input  logic [IW-1:0]       thr_idx,
  output logic signed [W-1:0] thr_val
);

  logic signed [W-1:0] wt_q  [N][N];
  logic signed [W-1:0] thr_q [N];

  logic                row_ok;
  logic                col_ok;
  logic signed [W-1:0] wt_new;
  logic signed [W-1:0] thr_new;

  assign row_ok = int'(wr_row) < N;
  assign col_ok = int'(wr_col) < N;

  always_comb begin
    wt_new  = wr_data;
    thr_new = wr_data;
    if (row_ok && col_ok && wr_accum)
      wt_new = W'(hop_pkg::hop_sat_add(int'(wt_q[wr_row][wr_col]), int'(wr_data), W));
    if (row_ok && wr_accum)
      thr_new = W'(hop_pkg::hop_sat_add(int'(thr_q[wr_row]), int'(wr_data), W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        thr_q[r] <= '0;
        for (int c = 0; c < N; c++) wt_q[r][c] <= '0;
      end
    end else if (wr_en && row_ok) begin
      if (wr_thr) begin
        thr_q[wr_row] <= thr_new;
      end else if (col_ok && (wr_row != wr_col)) begin
        wt_q[wr_row][wr_col] <= wt_new;
        wt_q[wr_col][wr_row] <= wt_new;
      end
    end
  end

  assign rd_weight = wt_q[rd_src][rd_dst];
  assign thr_val   = thr_q[thr_idx];

endmodule

// File: rtl/hop_grad_acc.sv
module hop_grad_acc #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int AW = W + $clog2(N + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [W-1:0]  load_val,
  input  logic                 add,
  input  logic signed [W-1:0]  term,
  output logic signed [AW-1:0] sum_now
);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] term_x;
  logic signed [AW-1:0] load_x;

  assign term_x  = {{(AW-W){term[W-1]}}, term};
  assign load_x  = {{(AW-W){load_val[W-1]}}, load_val};
  assign sum_now = acc_q + term_x;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= load_x;
    else if (add)  acc_q <= sum_now;
  end

endmodule

// File: rtl/hop_sequencer.sv
module hop_sequencer #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          nbr_changed,
  output logic          running,
  output logic [IW-1:0] cur_k,
  output logic [IW-1:0] cur_j,
  output logic          last_term,
  output logic          load_acc,
  output logic [IW-1:0] thr_idx,
  output logic          conv
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  hop_pkg::seq_state_e state_q;
  logic                dirty_q;
  logic                last_neuron;
  logic                start_ok;

  assign running     = (state_q == hop_pkg::ST_SWEEP);
  assign start_ok    = start && !running;
  assign last_term   = running && (cur_j == LAST);
  assign last_neuron = (cur_k == LAST);
  assign load_acc    = start_ok || last_term;
  assign conv        = last_term && last_neuron && !dirty_q && !nbr_changed;

  always_comb begin
    if (!running || last_neuron) thr_idx = '0;
    else                         thr_idx = cur_k + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= hop_pkg::ST_IDLE;
      cur_k   <= '0;
      cur_j   <= '0;
      dirty_q <= 1'b0;
    end else if (start_ok) begin
      state_q <= hop_pkg::ST_SWEEP;
      cur_k   <= '0;
      cur_j   <= '0;
      dirty_q <= 1'b0;
    end else if (running) begin
      if (!last_term) begin
        cur_j <= cur_j + 1'b1;
      end else begin
        cur_j <= '0;
        if (last_neuron) begin
          cur_k   <= '0;
          dirty_q <= 1'b0;
          if (!(dirty_q || nbr_changed)) state_q <= hop_pkg::ST_IDLE;
        end else begin
          cur_k   <= cur_k + 1'b1;
          dirty_q <= dirty_q || nbr_changed;
        end
      end
    end
  end

endmodule

// File: rtl/hop_engine.sv
module hop_engine #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = W + $clog2(N + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_thr,
  input  logic                wr_accum,
  input  logic [IW-1:0]       wr_row,
  input  logic [IW-1:0]       wr_col,
  input  logic signed [W-1:0] wr_data,
  input  logic [N-1:0]        clamp_en,
  input  logic [N-1:0]        clamp_val,
  input  logic                start,
  output logic                stable,
  output logic [N-1:0]        act
);

  logic                 running;
  logic [IW-1:0]        cur_k;
  logic [IW-1:0]        cur_j;
  logic                 last_term;
  logic                 load_acc;
  logic [IW-1:0]        thr_idx;
  logic                 conv;
  logic signed [W-1:0]  rd_weight;
  logic signed [W-1:0]  thr_val;
  logic signed [W-1:0]  term;
  logic signed [AW-1:0] grad;
  logic                 upd_fire;
  logic                 k_clamped;
  logic                 nxt_bit;
  logic                 nbr_changed;
  logic                 start_ok;
  logic                 grad_pos;
  logic                 grad_neg;

  hop_param_store #(.N(N), .W(W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_thr(wr_thr), .wr_accum(wr_accum),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .rd_src(cur_j), .rd_dst(cur_k), .rd_weight(rd_weight),
    .thr_idx(thr_idx), .thr_val(thr_val)
  );

  hop_sequencer #(.N(N)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nbr_changed(nbr_changed),
    .running(running), .cur_k(cur_k), .cur_j(cur_j), .last_term(last_term),
    .load_acc(load_acc), .thr_idx(thr_idx), .conv(conv)
  );

  // Skip the self term and neurons that are off.
  assign term = ((cur_j != cur_k) && act[cur_j]) ? rd_weight : '0;

  hop_grad_acc #(.N(N), .W(W)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .load(load_acc), .load_val(thr_val),
    .add(running), .term(term), .sum_now(grad)
  );

  assign start_ok    = start && !running;
  assign upd_fire    = last_term;
  assign k_clamped   = clamp_en[cur_k];
  assign nxt_bit     = hop_pkg::hop_next_bit(act[cur_k], int'(grad));
  assign nbr_changed = upd_fire && !k_clamped && (nxt_bit != act[cur_k]);
  assign grad_pos    = grad > 0;
  assign grad_neg    = grad < 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
    end else if (start_ok) begin
      act <= (act & ~clamp_en) | (clamp_val & clamp_en);
    end else if (upd_fire && !k_clamped) begin
      act[cur_k] <= nxt_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        stable <= 1'b0;
    else if (start_ok) stable <= 1'b0;
    else if (conv)     stable <= 1'b1;
  end

endmodule

// File: rtl/hop_engine_chk.sv
module hop_engine_chk #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stable,
  input logic [N-1:0]  act,
  input logic [N-1:0]  clamp_en,
  input logic [N-1:0]  clamp_val,
  input logic          running,
  input logic [IW-1:0] cur_k,
  input logic          upd_fire,
  input logic          grad_pos,
  input logic          grad_neg
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> !stable); // R7

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($countones(act ^ $past(act)) <= 1)); // R5

  AST_K_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_k) < N)); // R5

  AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (((act ^ clamp_val) & clamp_en) == '0)); // R6

  AST_RAISE_ON_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !clamp_en[cur_k] && grad_pos) |=> act[$past(cur_k)]); // R4

  AST_LOWER_ON_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !clamp_en[cur_k] && grad_neg) |=> !act[$past(cur_k)]); // R4

  AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !grad_pos && !grad_neg) |=> $stable(act)); // R4

  AST_STABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && !start) |=> ($stable(act) && stable)); // R9

endmodule

bind hop_engine hop_engine_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .stable(stable), .act(act),
  .clamp_en(clamp_en), .clamp_val(clamp_val), .running(running),
  .cur_k(cur_k), .upd_fire(upd_fire), .grad_pos(grad_pos), .grad_neg(grad_neg)
);

// File: tb/hop_engine_tb_top.sv
module hop_engine_tb_top;

  localparam int N          = 6;
  localparam int W          = 8;
  localparam int IW         = $clog2(N);
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [N-1:0] exp_act;
    int           exp_lat;
    int           c0;
    string        req;
  } sb_item_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr_en = 1'b0;
  logic                wr_thr = 1'b0;
  logic                wr_accum = 1'b0;
  logic [IW-1:0]       wr_row = '0;
  logic [IW-1:0]       wr_col = '0;
  logic signed [W-1:0] wr_data = '0;
  logic [N-1:0]        clamp_en = '0;
  logic [N-1:0]        clamp_val = '0;
  logic                start = 1'b0;
  logic                stable;
  logic [N-1:0]        act;

  int       checks = 0;
  int       errors = 0;
  int       cyc = 0;
  logic     stab_d = 1'b0;
  sb_item_t sb_q[$];

  // bench's own copy of the network
  int           mw [N][N];
  int           mi [N];
  logic [N-1:0] mv;

  hop_engine #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_thr(wr_thr),
    .wr_accum(wr_accum), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .clamp_en(clamp_en), .clamp_val(clamp_val), .start(start),
    .stable(stable), .act(act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  function automatic int clip(input int v);
    int top;
    top = 2 ** (W - 1);
    if (v >= top) return top - 1;
    if (v < -top) return -top;
    return v;
  endfunction

  task automatic wr(input bit thr, input bit accum, input int row, input int col, input int data);
    if (thr) begin
      mi[row] = accum ? clip(mi[row] + data) : data;
    end else if (row != col) begin
      int nv;
      nv = accum ? clip(mw[row][col] + data) : data;
      mw[row][col] = nv;
      mw[col][row] = nv;
    end
    @(negedge clk);
    wr_en    = 1'b1;
    wr_thr   = thr;
    wr_accum = accum;
    wr_row   = IW'(row);
    wr_col   = IW'(col);
    wr_data  = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model_run(input logic [N-1:0] ce, input logic [N-1:0] cv,
                           output logic [N-1:0] res, output int sweeps);
    logic [N-1:0] v;
    bit           moved;
    v      = (mv & ~ce) | (cv & ce);
    sweeps = 0;
    do begin
      moved = 0;
      sweeps++;
      for (int k = 0; k < N; k++) begin
        int g;
        if (ce[k]) continue;
        g = mi[k];
        for (int j = 0; j < N; j++)
          if (j != k && v[j]) g += mw[j][k];
        if (g > 0 && !v[k]) begin v[k] = 1'b1; moved = 1; end
        if (g < 0 &&  v[k]) begin v[k] = 1'b0; moved = 1; end
      end
    end while (moved && sweeps < 50);
    res = v;
  endtask

  task automatic run_case(input string req, input logic [N-1:0] ce, input logic [N-1:0] cv);
    sb_item_t it;
    logic [N-1:0] res;
    int sw;
    model_run(ce, cv, res, sw);
    mv = res;
    @(negedge clk);
    clamp_en  = ce;
    clamp_val = cv;
    start     = 1'b1;
    it.exp_act = res;
    it.exp_lat = sw * N * N;
    it.c0      = cyc;
    it.req     = req;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check(stable == 1'b0, "R7", "stable after start", int'(stable), 0);
    while (!stable) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops an expected item on every rise of stable
  always @(negedge clk) begin
    if (rst_n && stable && !stab_d) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "unexpected stable rise", 1, 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(act == it.exp_act, it.req, "settled activations",
              int'(act), int'(it.exp_act));
        check((cyc - it.c0 - 1) == it.exp_lat, "R7", "start-to-stable cycles",
              cyc - it.c0 - 1, it.exp_lat);
      end
    end
    stab_d = stable;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      mi[r] = 0;
      for (int c = 0; c < N; c++) mw[r][c] = 0;
    end
    mv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(act == '0, "R1", "reset activations", int'(act), 0);
    check(stable == 1'b0, "R1", "reset stable", int'(stable), 0);

    // R1: zero network settles in one sweep to all zeros
    run_case("R1", '0, '0);

    // gate A: neurons 0,1 -> 2; edge written reversed (R2 symmetry), one by accumulate
    wr(0, 0, 2, 0, 4);
    wr(0, 1, 1, 2, 4);
    wr(0, 0, 0, 1, -2);
    wr(1, 0, 2, 0, -6);

    run_case("R4", 6'b000011, 6'b000011);   // forward: 1 AND 1 -> 1
    run_case("R2", 6'b000011, 6'b000001);   // forward: 1 AND 0 -> 0
    run_case("R6", 6'b000100, 6'b000100);   // backward: output forced 1
    run_case("R4", 6'b000101, 6'b000000);   // zero gradient keeps neuron 1

    // gate B merged: neurons 2,3 -> 4, threshold of 2 accumulated
    wr(1, 1, 2, 0, 0);
    wr(0, 1, 2, 4, 4);
    wr(0, 0, 3, 4, 4);
    wr(0, 1, 2, 3, -2);
    wr(1, 1, 4, 0, -6);
    run_case("R8", 6'b010000, 6'b010000);   // justify through two gates

    // R2 positive saturation on isolated neuron 5
    wr(1, 1, 5, 0, 100);
    wr(1, 1, 5, 0, 100);
    run_case("R2", 6'b000000, 6'b000000);

    // R3 self-edge write must not pull neuron 5 down
    wr(0, 0, 5, 5, -128);
    run_case("R3", 6'b000000, 6'b000000);

    // R2 negative saturation
    wr(1, 1, 5, 0, -128);
    wr(1, 1, 5, 0, -128);
    wr(1, 1, 5, 0, -128);
    run_case("R2", 6'b000000, 6'b000000);

    // R9: act frozen while stable with no start
    begin
      logic [N-1:0] snap;
      snap = act;
      repeat (20) @(negedge clk);
      check(act == snap && stable, "R9", "frozen while stable", int'(act), int'(snap));
    end
    // R5 is also covered by the exact sweep-length checks above

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule